// File: doc/BRIEF.md
# Power-Down Entry Sequencer

This block decides when a processor core may drop into its deepest power-down state. Software asks for power-down through two flag bits of the power-control register. The arming flag sits in bit 1 and the start flag sits in bit 6. Power-down begins only when two instructions run back to back. The first sets the arming flag and not the start flag. The second sets the start flag and not the arming flag. The block tracks register writes within each instruction and judges the sequence at every instruction-boundary strobe. Once it commits, it requests that the clocks stop and that the address-latch and program-store strobes be held low.

The external enable/wake pin must be low for the feature to work. Awake, the pin goes through a synchronizer. Powered down, no clock runs, so an asynchronous edge catcher watches the pin. A rising edge raises a wake-reset request, and the system reset controller answers it with the asynchronous reset. That reset clears the block and lets the clocks run again. The two flag bits are never stored. The block strips them from the write data it passes on and forces them to 0 on readback. All other register bits pass through unchanged.

The controller has three states:
- `PD_IDLE` is the reset state.
- `PD_ARMED` is held for one instruction.
- `PD_DOWN` holds until reset.

It has these transitions:
- arm (IDLE to ARMED, on an arming instruction with the pin low)
- rearm (ARMED to ARMED, on another arming instruction)
- commit (ARMED to DOWN, on a start instruction with the pin low)
- disarm (ARMED to IDLE, on any other instruction, or with the pin high)
- wake/reset (any state to IDLE, through the asynchronous reset)

Top module: `pd_entry_ctrl`

## Requirements
- R1: After the asynchronous reset, clk_stop_req, strobe_hold_low and wake_rst_req are all 0.
- R2: An instruction writing bit 1 = 1 with bit 6 = 0, then the very next instruction writing bit 6 = 1 with bit 1 = 0, raises clk_stop_req and strobe_hold_low after the clock edge that samples the second instruction's boundary strobe.
- R3: A write that sets bits 1 and 6 together neither arms nor enters power-down. A start write that follows it has no effect.
- R4: A start write (bit 6 = 1, bit 1 = 0) without an arming instruction just before it does not enter power-down.
- R5: If the instruction after an arming one is anything else, the block disarms. This covers an instruction with no register write and a write with neither flag bit set. A later start write then has no effect.
- R6: An arming instruction that follows another arming instruction keeps the block armed, so a start write next enters power-down.
- R7: While the synchronized wake pin is high, arming and start writes are ignored and power-down is not entered.
- R8: In power-down, a rising edge on wake_pin raises wake_rst_req with no clock edge needed. Outside power-down, wake_rst_req stays 0 whatever the pin does.
- R9: Power-down and its outputs hold until the asynchronous reset, which clears clk_stop_req, strobe_hold_low and wake_rst_req.
- R10: pcon_rdata_out equals pcon_rdata_in with bits 1 and 6 forced to 0.
- R11: pcon_wdata_out equals pcon_wdata with bits 1 and 6 forced to 0, and pcon_wr_out follows pcon_wr.
- R12: Entry happens only at an instruction boundary. A start write made before the boundary strobe of its instruction does not enter power-down until that strobe.
- R13: Flag writes are combined over the whole instruction. An instruction that writes the arming bit in one write and the start bit in another counts as both set and disarms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (stopped externally during power-down) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcon_wr | input | 1 | Write strobe to the power-control register |
| pcon_wdata | input | 8 | Write data for the power-control register |
| insn_done | input | 1 | One-cycle strobe marking the end of an instruction |
| wake_pin | input | 1 | External enable/wake pin, must be low to allow power-down |
| pcon_rdata_in | input | 8 | Stored register contents from the register file |
| pcon_wr_out | output | 1 | Write strobe forwarded to the register storage |
| pcon_wdata_out | output | 8 | Write data forwarded, flag bits removed |
| pcon_rdata_out | output | 8 | Readback value, flag bits read as 0 |
| clk_stop_req | output | 1 | Request to stop both clock sources |
| strobe_hold_low | output | 1 | Request to drive the address-latch and program-store strobes low |
| wake_rst_req | output | 1 | Request for a system reset after a wake edge |

## Verification
The assertions rely on a few input conventions:
- insn_done is a single-cycle pulse.
- Writes fall inside an instruction, so each write is counted toward the next boundary strobe.
- wake_pin is held stable long enough for the two-stage synchronizer to settle before the state machine acts on it.
- The reset controller answers wake_rst_req with rst_n.

The stimulus drives every input on the falling clock edge, with each write and boundary strobe lasting one cycle. After each wake-pin change it waits several cycles before issuing instructions. After every wake it applies rst_n, so the asynchronous edge catcher and the clocked state never race.

// File: rtl/pd_entry_pkg.sv
`timescale 1ns/1ps
package pd_entry_pkg;

    typedef enum logic [1:0] {
        PD_IDLE  = 2'd0,
        PD_ARMED = 2'd1,
        PD_DOWN  = 2'd2
    } pd_state_e;

    typedef enum logic [1:0] {
        INSN_OTHER = 2'd0,
        INSN_ARM   = 2'd1,
        INSN_START = 2'd2
    } insn_kind_e;

endpackage

// File: rtl/pd_insn_classify.sv
`timescale 1ns/1ps
// Gathers flag-bit writes over one instruction and reports its kind at the boundary.
module pd_insn_classify
    import pd_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_arm_bit,
    input  logic       wr_start_bit,
    input  logic       insn_done,
    output insn_kind_e kind
);

    logic acc_arm_q;
    logic acc_start_q;
    logic seen_arm;
    logic seen_start;

    assign seen_arm   = acc_arm_q   | (wr_en & wr_arm_bit);
    assign seen_start = acc_start_q | (wr_en & wr_start_bit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_arm_q   <= 1'b0;
            acc_start_q <= 1'b0;
        end else if (insn_done) begin
            acc_arm_q   <= 1'b0;
            acc_start_q <= 1'b0;
        end else begin
            acc_arm_q   <= seen_arm;
            acc_start_q <= seen_start;
        end
    end

    always_comb begin
        if (seen_arm && !seen_start) begin
            kind = INSN_ARM;
        end else if (seen_start && !seen_arm) begin
            kind = INSN_START;
        end else begin
            kind = INSN_OTHER;
        end
    end

endmodule

// File: rtl/pd_wake_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for the wake pin while the clock runs.
module pd_wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_async};
        end
    end

    assign pin_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pd_wake_edge.sv
`timescale 1ns/1ps
// Clockless rising-edge catcher, held clear whenever arm_n is low.
module pd_wake_edge (
    input  logic pin,
    input  logic arm_n,
    output logic caught
);

    always_ff @(posedge pin or negedge arm_n) begin
        if (!arm_n) begin
            caught <= 1'b0;
        end else begin
            caught <= 1'b1;
        end
    end

endmodule

// File: rtl/pd_reg_mask.sv
`timescale 1ns/1ps
// Removes the self-clearing flag bits from the write and read paths.
module pd_reg_mask #(
    parameter int DATA_W    = 8,
    parameter int ARM_BIT   = 1,
    parameter int START_BIT = 6
) (
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [DATA_W-1:0] wdata_out,
    output logic [DATA_W-1:0] rdata_out
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b == ARM_BIT || b == START_BIT) begin : g_flag
            assign wdata_out[b] = 1'b0;
            assign rdata_out[b] = 1'b0;
        end else begin : g_pass
            assign wdata_out[b] = wdata_in[b];
            assign rdata_out[b] = rdata_in[b];
        end
    end

endmodule

// File: rtl/pd_entry_ctrl.sv
`timescale 1ns/1ps
// Power-down entry sequencer: two-instruction unlock, pin-edge wake.
module pd_entry_ctrl
    import pd_entry_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ARM_BIT     = 1,
    parameter int START_BIT   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pcon_wr,
    input  logic [DATA_W-1:0] pcon_wdata,
    input  logic              insn_done,
    input  logic              wake_pin,
    input  logic [DATA_W-1:0] pcon_rdata_in,
    output logic              pcon_wr_out,
    output logic [DATA_W-1:0] pcon_wdata_out,
    output logic [DATA_W-1:0] pcon_rdata_out,
    output logic              clk_stop_req,
    output logic              strobe_hold_low,
    output logic              wake_rst_req
);

    pd_state_e  state_q;
    pd_state_e  state_d;
    insn_kind_e kind;
    logic       pin_high_s;
    logic       pin_low;
    logic       armed_w;
    logic       down_w;
    logic       edge_arm_n;

    pd_insn_classify u_classify (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (pcon_wr),
        .wr_arm_bit   (pcon_wdata[ARM_BIT]),
        .wr_start_bit (pcon_wdata[START_BIT]),
        .insn_done    (insn_done),
        .kind         (kind)
    );

    pd_wake_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (wake_pin),
        .pin_sync  (pin_high_s)
    );

    assign pin_low = ~pin_high_s;

    pd_reg_mask #(
        .DATA_W    (DATA_W),
        .ARM_BIT   (ARM_BIT),
        .START_BIT (START_BIT)
    ) u_mask (
        .wdata_in  (pcon_wdata),
        .rdata_in  (pcon_rdata_in),
        .wdata_out (pcon_wdata_out),
        .rdata_out (pcon_rdata_out)
    );

    assign pcon_wr_out = pcon_wr;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: arm, rearm, commit, disarm.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_IDLE: begin
                if (insn_done && pin_low && kind == INSN_ARM) begin
                    state_d = PD_ARMED;
                end
            end
            PD_ARMED: begin
                if (insn_done) begin
                    if (!pin_low) begin
                        state_d = PD_IDLE;
                    end else if (kind == INSN_START) begin
                        state_d = PD_DOWN;
                    end else if (kind == INSN_ARM) begin
                        state_d = PD_ARMED;
                    end else begin
                        state_d = PD_IDLE;
                    end
                end
            end
            PD_DOWN: begin
                state_d = PD_DOWN;
            end
            default: begin
                state_d = PD_IDLE;
            end
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        armed_w = 1'b0;
        down_w  = 1'b0;
        unique case (state_q)
            PD_IDLE:  ;
            PD_ARMED: armed_w = 1'b1;
            PD_DOWN:  down_w  = 1'b1;
            default:  ;
        endcase
    end

    assign clk_stop_req    = down_w;
    assign strobe_hold_low = down_w;

    assign edge_arm_n = rst_n & down_w;

    pd_wake_edge u_edge (
        .pin    (wake_pin),
        .arm_n  (edge_arm_n),
        .caught (wake_rst_req)
    );

endmodule

// File: rtl/pd_entry_ctrl_chk.sv
`timescale 1ns/1ps
module pd_entry_ctrl_chk #(
    parameter int DATA_W    = 8,
    parameter int ARM_BIT   = 1,
    parameter int START_BIT = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pcon_wr,
    input logic [DATA_W-1:0] pcon_wdata,
    input logic              insn_done,
    input logic              armed,
    input logic              pin_low,
    input logic              clk_stop_req,
    input logic              wake_rst_req
);

    // R2 / R12: entry lands only at an instruction boundary
    a_r2_entry_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_stop_req) |-> $past(insn_done));

    // R4: entry requires the armed state one instruction earlier
    a_r4_entry_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_stop_req) |-> $past(armed));

    // R3: simultaneous flag write never starts power-down
    a_r3_both_bits_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && pcon_wr && pcon_wdata[ARM_BIT] && pcon_wdata[START_BIT] && !clk_stop_req)
        |=> !clk_stop_req);

    // R7: high pin blocks entry
    a_r7_pin_high_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_stop_req && !pin_low) |=> !clk_stop_req);

    // R9: power-down holds until reset
    a_r9_down_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop_req |=> clk_stop_req);

    // R8: wake request only while powered down
    a_r8_wake_only_down: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rst_req |-> clk_stop_req);

endmodule

bind pd_entry_ctrl pd_entry_ctrl_chk #(
    .DATA_W    (DATA_W),
    .ARM_BIT   (ARM_BIT),
    .START_BIT (START_BIT)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pcon_wr      (pcon_wr),
    .pcon_wdata   (pcon_wdata),
    .insn_done    (insn_done),
    .armed        (armed_w),
    .pin_low      (pin_low),
    .clk_stop_req (clk_stop_req),
    .wake_rst_req (wake_rst_req)
);

// File: tb/test_pd_entry_ctrl.sv
`timescale 1ns/1ps
module test_pd_entry_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pcon_wr = 1'b0;
    logic [7:0] pcon_wdata = 8'h00;
    logic       insn_done = 1'b0;
    logic       wake_pin = 1'b0;
    logic [7:0] pcon_rdata_in = 8'h00;
    logic       pcon_wr_out;
    logic [7:0] pcon_wdata_out;
    logic [7:0] pcon_rdata_out;
    logic       clk_stop_req;
    logic       strobe_hold_low;
    logic       wake_rst_req;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pd_entry_ctrl i_pd_entry_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .pcon_wr         (pcon_wr),
        .pcon_wdata      (pcon_wdata),
        .insn_done       (insn_done),
        .wake_pin        (wake_pin),
        .pcon_rdata_in   (pcon_rdata_in),
        .pcon_wr_out     (pcon_wr_out),
        .pcon_wdata_out  (pcon_wdata_out),
        .pcon_rdata_out  (pcon_rdata_out),
        .clk_stop_req    (clk_stop_req),
        .strobe_hold_low (strobe_hold_low),
        .wake_rst_req    (wake_rst_req)
    );

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // One complete instruction: optional write plus boundary strobe in one cycle.
    task automatic insn(input logic wr, input logic [7:0] d);
        @(negedge clk);
        pcon_wr    = wr;
        pcon_wdata = d;
        insn_done  = 1'b1;
        @(negedge clk);
        pcon_wr    = 1'b0;
        pcon_wdata = 8'h00;
        insn_done  = 1'b0;
    endtask

    task automatic write_only(input logic [7:0] d);
        @(negedge clk);
        pcon_wr    = 1'b1;
        pcon_wdata = d;
        @(negedge clk);
        pcon_wr    = 1'b0;
        pcon_wdata = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R9 reset clears clk_stop_req", clk_stop_req, 0);
        chk("R9 reset clears strobe_hold_low", strobe_hold_low, 0);
        chk("R9 reset clears wake_rst_req", wake_rst_req, 0);
        @(negedge clk);
        wake_pin = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 clk_stop_req after reset", clk_stop_req, 0);
        chk("R1 strobe_hold_low after reset", strobe_hold_low, 0);
        chk("R1 wake_rst_req after reset", wake_rst_req, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 idle after release", clk_stop_req, 0);
    endtask

    task automatic t_entry_and_wake();
        insn(1'b1, 8'h02);
        chk("R2 armed, not yet down", clk_stop_req, 0);
        insn(1'b1, 8'h40);
        chk("R2 clk_stop_req after start", clk_stop_req, 1);
        chk("R2 strobe_hold_low after start", strobe_hold_low, 1);
        chk("R8 no wake before edge", wake_rst_req, 0);
        repeat (3) @(negedge clk);
        chk("R9 still down", clk_stop_req, 1);
        #0.5;
        wake_pin = 1'b1;
        #0.5;
        chk("R8 wake request without clock edge", wake_rst_req, 1);
        do_reset();
    endtask

    task automatic t_both_bits();
        insn(1'b1, 8'h42);
        chk("R3 both bits no entry", clk_stop_req, 0);
        insn(1'b1, 8'h40);
        chk("R3 both bits did not arm", clk_stop_req, 0);
    endtask

    task automatic t_start_only();
        insn(1'b1, 8'h40);
        chk("R4 start without arm", clk_stop_req, 0);
    endtask

    task automatic t_disarm();
        insn(1'b1, 8'h02);
        insn(1'b0, 8'h00);
        insn(1'b1, 8'h40);
        chk("R5 disarm on non-write instruction", clk_stop_req, 0);
        insn(1'b1, 8'h02);
        insn(1'b1, 8'h01);
        insn(1'b1, 8'h40);
        chk("R5 disarm on other-bit write", clk_stop_req, 0);
    endtask

    task automatic t_rearm();
        insn(1'b1, 8'h02);
        insn(1'b1, 8'h02);
        chk("R6 still not down after rearm", clk_stop_req, 0);
        insn(1'b1, 8'h40);
        chk("R6 entry after rearm", clk_stop_req, 1);
        do_reset();
    endtask

    task automatic t_pin_high();
        wake_pin = 1'b1;
        repeat (4) @(negedge clk);
        insn(1'b1, 8'h02);
        insn(1'b1, 8'h40);
        chk("R7 pin high blocks entry", clk_stop_req, 0);
        chk("R8 no wake request outside power-down", wake_rst_req, 0);
        wake_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_boundary();
        insn(1'b1, 8'h02);
        write_only(8'h40);
        chk("R12 no entry before boundary", clk_stop_req, 0);
        @(negedge clk);
        chk("R12 still waiting for boundary", clk_stop_req, 0);
        insn(1'b0, 8'h00);
        chk("R12 entry at boundary", clk_stop_req, 1);
        do_reset();
    endtask

    task automatic t_two_writes();
        insn(1'b1, 8'h02);
        write_only(8'h02);
        insn(1'b1, 8'h40);
        chk("R13 split flag writes disarm", clk_stop_req, 0);
    endtask

    task automatic t_regpath();
        @(negedge clk);
        pcon_rdata_in = 8'hFF;
        pcon_wr       = 1'b1;
        pcon_wdata    = 8'hFF;
        #1;
        chk("R10 readback masks flags", pcon_rdata_out, 8'hBD);
        chk("R11 write data masks flags", pcon_wdata_out, 8'hBD);
        chk("R11 write strobe forwarded", pcon_wr_out, 1);
        pcon_rdata_in = 8'h5A;
        pcon_wdata    = 8'h25;
        #1;
        chk("R10 readback other bits pass", pcon_rdata_out, 8'h18);
        chk("R11 write other bits pass", pcon_wdata_out, 8'h25);
        @(negedge clk);
        pcon_wr    = 1'b0;
        pcon_wdata = 8'h00;
        #1;
        chk("R11 write strobe idle", pcon_wr_out, 0);
        insn(1'b0, 8'h00);
    endtask

    initial begin
        t_reset();
        t_entry_and_wake();
        t_both_bits();
        t_start_only();
        t_disarm();
        t_rearm();
        t_pin_high();
        t_boundary();
        t_two_writes();
        t_regpath();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule